// File: doc/BRIEF.md
# Configuration Register Responder for One Bus Function

This block answers configuration cycles for a single function on a simplified parallel bus. It uses a shared 32-bit address/data input. The host places an address on that input in a request cycle and write data on it in the following cycle. A dedicated select line marks the access as aimed at this function. The block never compares the high address bits against a base. It claims the access only when the select line is high, the function field matches the implemented function (number zero), and the two lowest address bits are zero.

Behind the decoder sits a 256-byte space organised as 64 dwords. Most of it is sparse:
- Identity words are read-only.
- A command word drives the memory-enable and I/O-enable outputs.
- An interrupt-line byte is writable.
- Up to six base address registers are fixed in size by parameters.

Enumeration software sizes a base register by writing all ones and reading back. The bits below the size boundary come back as zero, and bit 0 reports the register type. Every other offset reads zero.

Top module: `cfg_space_target`

## Requirements
- R1: A request cycle (reqValid high) carries the address and is followed by one data phase, in which cfgAd holds write data and byteEn is sampled. respValid pulses high for exactly one cycle, on the second rising edge after the request edge. A new request may start in the cycle that follows the data phase.
- R2: A request with cfgIdsel low is not claimed. It gets respClaim=0 and respData=32'hFFFFFFFF, and a write changes no register.
- R3: Only cfgAd[10:0] of the address are decoded. Bits 7:2 select the dword, bits 10:8 must equal 0 (the only function implemented), and bits 1:0 must be 00. Otherwise the access is unclaimed. Bits 31:11 have no effect.
- R4: Dword 0 reads {DEVICE_ID[15:0], VENDOR_ID[15:0]} and ignores writes.
- R5: Dword 2 reads {CLASS_CODE[23:0], REVISION[7:0]} and dword 11 reads {SUBSYS_ID[15:0], SUBSYS_VENDOR[15:0]}. Both ignore writes.
- R6: In dword 1, bits 15:0 form the command field. Only the bits in mask 16'h0547 are writable. Bit 0 drives ioEnable, bit 1 drives memEnable, and bits 31:16 read zero.
- R7: A claimed write changes only the bytes whose byteEn bit is high; byteEn[i] covers data bits 8i+7:8i.
- R8: Base registers occupy dwords 4 to 9, and the first NUM_BARS of them are implemented. After an all-ones write, a base register of size 2^k reads ones in bits 31:k and zero in bits k-1:1. Bit 0 reads 1 for an I/O register and 0 for a memory register.
- R9: The effective size is at least 16 bytes for memory and at least 4 bytes for I/O, whatever the parameter says. The type bits ignore writes, and an unimplemented base register reads zero.
- R10: In dword 15, only bits 7:0 (interrupt line) are writable. The remaining bits of that dword, and every offset not listed in R4 to R9, read zero.
- R11: After reset, respValid, the command field, ioEnable, memEnable, every base register and the interrupt line are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request cycle: cfgAd holds the address |
| reqWrite | input | 1 | Request is a write (sampled with reqValid) |
| cfgIdsel | input | 1 | Function select (sampled with reqValid) |
| cfgAd | input | 32 | Multiplexed address (request cycle) / write data (data phase) |
| byteEn | input | 4 | Active-high byte enables (data phase) |
| respValid | output | 1 | One-cycle response pulse |
| respClaim | output | 1 | Access was claimed |
| respData | output | 32 | Read data, zero for claimed writes, all ones if unclaimed |
| ioEnable | output | 1 | Command bit 0 |
| memEnable | output | 1 | Command bit 1 |

## Verification
Most internal faults in this block show up at the ports on the very next response. A claim flag latched wrongly flips respClaim and turns respData into all ones two edges after the request. A wrong size mask in stored base-register bits shows on the first read after an all-ones write. A write strobe leaking into a read-only word, or a disabled byte, stays hidden until that word is read again. For that reason, each write scenario in the bench reads the target back at once, and the command bits are also visible without any delay on ioEnable and memEnable.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned MAX_BARS    = 6;
  localparam int unsigned IDX_W       = 6;
  localparam logic [IDX_W-1:0] IDX_ID      = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CMD     = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS   = 6'd2;
  localparam logic [IDX_W-1:0] IDX_BAR0    = 6'd4;
  localparam logic [IDX_W-1:0] IDX_SUBSYS  = 6'd11;
  localparam logic [IDX_W-1:0] IDX_INTR    = 6'd15;
  localparam logic [2:0]       OWN_FUNC    = 3'd0;
  localparam logic [15:0]      CMD_WMASK   = 16'h0547;

  typedef enum logic {PH_IDLE, PH_DATA} phase_t;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [IDX_W-1:0] regIdx;
  } cfg_strobe_t;
endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        cfgIdsel,
  input  logic [31:0] cfgAd,
  input  logic [31:0] rdData,
  output cfg_strobe_t strb,
  output logic        respValid,
  output logic        respClaim,
  output logic [31:0] respData
);
  phase_t           phase;
  logic [IDX_W-1:0] idxQ;
  logic             claimQ;
  logic             wrQ;
  logic             claimNext;
  logic             unusedAddrBits;

  // Upper address lines are never compared: selection comes from cfgIdsel.
  assign unusedAddrBits = ^cfgAd[31:11];
  assign claimNext = cfgIdsel && (cfgAd[10:8] == OWN_FUNC) && (cfgAd[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      idxQ      <= '0;
      claimQ    <= 1'b0;
      wrQ       <= 1'b0;
      respValid <= 1'b0;
      respClaim <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase  <= PH_DATA;
            idxQ   <= cfgAd[7:2];
            claimQ <= claimNext;
            wrQ    <= reqWrite;
          end
        end
        PH_DATA: begin
          phase     <= PH_IDLE;
          respValid <= 1'b1;
          respClaim <= claimQ;
          if (!claimQ)  respData <= '1;
          else if (wrQ) respData <= '0;
          else          respData <= rdData;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.regIdx = idxQ;
    strb.wrEn   = (phase == PH_DATA) && claimQ && wrQ;
    strb.rdEn   = (phase == PH_DATA) && claimQ && !wrQ;
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && reqValid) |-> ##2 respValid); // R1
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R1
  AST_NO_IDSEL_NO_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && reqValid && !cfgIdsel) |-> ##2 (respValid && !respClaim)); // R2
  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> $past(cfgIdsel)); // R2
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h3C4D,
  parameter logic [15:0] DEVICE_ID     = 16'h1A2B,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h7081,
  parameter logic [15:0] SUBSYS_ID     = 16'h5E6F,
  parameter logic [23:0] CLASS_CODE    = 24'h028000,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter int unsigned NUM_BARS      = 3,
  parameter logic [MAX_BARS-1:0][4:0] BAR_LOG2 = {5'd0, 5'd0, 5'd0, 5'd20, 5'd8, 5'd12},
  parameter logic [MAX_BARS-1:0]      BAR_IO   = 6'b000010
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfg_strobe_t strb,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        ioEnable,
  output logic        memEnable
);
  logic [31:0] byteMask;
  logic [15:0] cmdQ;
  logic [7:0]  intLineQ;
  logic [31:0] barRd [MAX_BARS];

  assign byteMask = {{8{byteEn[3]}}, {8{byteEn[2]}}, {8{byteEn[1]}}, {8{byteEn[0]}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= '0;
      intLineQ <= '0;
    end else if (strb.wrEn) begin
      if (strb.regIdx == IDX_CMD) begin
        cmdQ <= (cmdQ & ~(byteMask[15:0] & CMD_WMASK)) |
                (wrData[15:0] & byteMask[15:0] & CMD_WMASK);
      end
      if (strb.regIdx == IDX_INTR && byteEn[0]) begin
        intLineQ <= wrData[7:0];
      end
    end
  end

  for (genvar g = 0; g < MAX_BARS; g++) begin : gBar
    if (g < NUM_BARS) begin : gImpl
      localparam int unsigned RAW_L   = int'(BAR_LOG2[g]);
      localparam int unsigned MIN_L   = BAR_IO[g] ? 2 : 4;
      localparam int unsigned EFF_L   = (RAW_L < MIN_L) ? MIN_L : RAW_L;
      localparam logic [31:0] ADDR_MASK = 32'hFFFF_FFFF << EFF_L;
      localparam logic [31:0] TYPE_BITS = {31'd0, BAR_IO[g]};
      logic [31:0] barQ;
      logic        hit;
      assign hit = strb.wrEn && (strb.regIdx == IDX_BAR0 + IDX_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    barQ <= '0;
        else if (hit) barQ <= (barQ & ~(byteMask & ADDR_MASK)) | (wrData & byteMask & ADDR_MASK);
      end
      assign barRd[g] = barQ | TYPE_BITS;

      AST_BAR_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
        (barQ & ~ADDR_MASK) == 32'd0); // R8
    end else begin : gNone
      assign barRd[g] = '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.regIdx)
        IDX_ID:     rdData = {DEVICE_ID, VENDOR_ID};
        IDX_CMD:    rdData = {16'd0, cmdQ};
        IDX_CLASS:  rdData = {CLASS_CODE, REVISION};
        IDX_SUBSYS: rdData = {SUBSYS_ID, SUBSYS_VENDOR};
        IDX_INTR:   rdData = {24'd0, intLineQ};
        6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9:
                    rdData = barRd[strb.regIdx - IDX_BAR0];
        default:    rdData = '0;
      endcase
    end
  end

  assign ioEnable  = cmdQ[0];
  assign memEnable = cmdQ[1];

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrEn && strb.regIdx == IDX_CMD) |=> $stable(cmdQ)); // R6
  AST_CMD_BYTE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.regIdx == IDX_CMD && !byteEn[0]) |=> $stable(cmdQ[7:0])); // R7
  AST_INTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrEn && strb.regIdx == IDX_INTR) |=> $stable(intLineQ)); // R10
endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h3C4D,
  parameter logic [15:0] DEVICE_ID     = 16'h1A2B,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h7081,
  parameter logic [15:0] SUBSYS_ID     = 16'h5E6F,
  parameter logic [23:0] CLASS_CODE    = 24'h028000,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter int unsigned NUM_BARS      = 3,
  parameter logic [MAX_BARS-1:0][4:0] BAR_LOG2 = {5'd0, 5'd0, 5'd0, 5'd20, 5'd8, 5'd12},
  parameter logic [MAX_BARS-1:0]      BAR_IO   = 6'b000010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        cfgIdsel,
  input  logic [31:0] cfgAd,
  input  logic [3:0]  byteEn,
  output logic        respValid,
  output logic        respClaim,
  output logic [31:0] respData,
  output logic        ioEnable,
  output logic        memEnable
);
  cfg_strobe_t strb;
  logic [31:0] rdData;

  cfg_space_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .cfgIdsel  (cfgIdsel),
    .cfgAd     (cfgAd),
    .rdData    (rdData),
    .strb      (strb),
    .respValid (respValid),
    .respClaim (respClaim),
    .respData  (respData)
  );

  cfg_space_regs #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .SUBSYS_VENDOR (SUBSYS_VENDOR),
    .SUBSYS_ID     (SUBSYS_ID),
    .CLASS_CODE    (CLASS_CODE),
    .REVISION      (REVISION),
    .NUM_BARS      (NUM_BARS),
    .BAR_LOG2      (BAR_LOG2),
    .BAR_IO        (BAR_IO)
  ) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteEn    (byteEn),
    .wrData    (cfgAd),
    .rdData    (rdData),
    .ioEnable  (ioEnable),
    .memEnable (memEnable)
  );
endmodule

// File: tb/test_cfg_space_target.sv
module test_cfg_space_target;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        cfgIdsel = 1'b0;
  logic [31:0] cfgAd = '0;
  logic [3:0]  byteEn = '0;
  logic        respValid, respClaim, ioEnable, memEnable;
  logic [31:0] respData;

  int errCount = 0;
  int chkCount = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // BAR1: I/O, log2 1 (clamped to 4 bytes); BAR2: memory, log2 2 (clamped to 16 bytes)
  cfg_space_target #(
    .NUM_BARS (3),
    .BAR_LOG2 ({5'd0, 5'd0, 5'd0, 5'd2, 5'd1, 5'd12}),
    .BAR_IO   (6'b000010)
  ) i_cfg_space_target (
    .clk, .rstN, .reqValid, .reqWrite, .cfgIdsel, .cfgAd, .byteEn,
    .respValid, .respClaim, .respData, .ioEnable, .memEnable
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgAcc(input bit wr, input bit sel, input logic [31:0] addr,
                        input logic [31:0] data, input logic [3:0] be,
                        output logic claim, output logic [31:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; cfgIdsel = sel; cfgAd = addr; byteEn = be;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; cfgIdsel = 1'b0; cfgAd = data; byteEn = be;
    @(negedge clk);
    cfgAd = '0; byteEn = '0;
    check("R1 respValid on second edge", {31'd0, respValid}, 32'd1);
    claim = respClaim;
    rd = respData;
  endtask

  task automatic expRead(input string tag, input logic [31:0] addr, input logic [31:0] exp);
    logic c; logic [31:0] d;
    cfgAcc(1'b0, 1'b1, addr, 32'd0, 4'hF, c, d);
    check({tag, " claim"}, {31'd0, c}, 32'd1);
    check(tag, d, exp);
  endtask

  task automatic doWrite(input logic [31:0] addr, input logic [31:0] data, input logic [3:0] be);
    logic c; logic [31:0] d;
    cfgAcc(1'b1, 1'b1, addr, data, be, c, d);
    check("R1 claimed write response", {c, d[30:0]}, 32'h8000_0000);
  endtask

  task automatic expUnclaimed(input string tag, input bit wr, input bit sel, input logic [31:0] addr);
    logic c; logic [31:0] d;
    cfgAcc(wr, sel, addr, 32'd0, 4'hF, c, d);
    check({tag, " claim"}, {31'd0, c}, 32'd0);
    check({tag, " data"}, d, 32'hFFFF_FFFF);
  endtask

  task automatic tReset();
    check("R11 respValid", {31'd0, respValid}, 32'd0);
    check("R11 enables", {30'd0, memEnable, ioEnable}, 32'd0);
    expRead("R11 command", 32'h04, 32'd0);
    expRead("R11 bar0", 32'h10, 32'd0);
    expRead("R11 intline", 32'h3C, 32'd0);
    @(negedge clk);
    check("R1 single pulse", {31'd0, respValid}, 32'd0);
  endtask

  task automatic tIdentity();
    expRead("R4 id", 32'h00, 32'h1A2B_3C4D);
    doWrite(32'h00, 32'hFFFF_FFFF, 4'hF);
    expRead("R4 id after write", 32'h00, 32'h1A2B_3C4D);
    expRead("R5 class", 32'h08, 32'h0280_0003);
    doWrite(32'h2C, 32'h0, 4'hF);
    expRead("R5 subsys", 32'h2C, 32'h5E6F_7081);
  endtask

  task automatic tCommand();
    doWrite(32'h04, 32'hFFFF_FFFF, 4'hF);
    expRead("R6 command mask", 32'h04, 32'h0000_0547);
    check("R6 enables", {30'd0, memEnable, ioEnable}, 32'd3);
    doWrite(32'h04, 32'h0, 4'b0010);
    expRead("R7 byte1 only", 32'h04, 32'h0000_0047);
    check("R7 enables kept", {30'd0, memEnable, ioEnable}, 32'd3);
  endtask

  task automatic tNoClaim();
    expUnclaimed("R2 write no idsel", 1'b1, 1'b0, 32'h04);
    expUnclaimed("R2 read no idsel", 1'b0, 1'b0, 32'h00);
    expRead("R2 command unchanged", 32'h04, 32'h0000_0047);
    expUnclaimed("R3 function 1 read", 1'b0, 1'b1, 32'h100);
    expUnclaimed("R3 function 7 write", 1'b1, 1'b1, 32'h704);
    expUnclaimed("R3 low bits nonzero", 1'b0, 1'b1, 32'h01);
    expRead("R3 command unchanged", 32'h04, 32'h0000_0047);
    expRead("R3 upper bits ignored", 32'hABCD_E800, 32'h1A2B_3C4D);
  endtask

  task automatic tBars();
    for (int i = 0; i < 4; i++) doWrite(32'h10 + 32'(i*4), 32'hFFFF_FFFF, 4'hF);
    expRead("R8 bar0 size 4K", 32'h10, 32'hFFFF_F000);
    expRead("R9 bar1 io min 4", 32'h14, 32'hFFFF_FFFD);
    expRead("R9 bar2 mem min 16", 32'h18, 32'hFFFF_FFF0);
    expRead("R9 bar3 unimplemented", 32'h1C, 32'h0);
    doWrite(32'h10, 32'h1234_5678, 4'hF);
    expRead("R8 bar0 programmed", 32'h10, 32'h1234_5000);
    doWrite(32'h18, 32'hAAAA_AAAA, 4'b1000);
    expRead("R7 bar2 byte3 only", 32'h18, 32'hAAFF_FFF0);
    doWrite(32'h14, 32'h0, 4'hF);
    expRead("R9 bar1 type kept", 32'h14, 32'h0000_0001);
  endtask

  task automatic tReserved();
    doWrite(32'h0C, 32'hFFFF_FFFF, 4'hF);
    expRead("R10 dword3 zero", 32'h0C, 32'h0);
    doWrite(32'h30, 32'hFFFF_FFFF, 4'hF);
    expRead("R10 dword12 zero", 32'h30, 32'h0);
    expRead("R10 dword63 zero", 32'hFC, 32'h0);
    doWrite(32'h3C, 32'hFFFF_FFFF, 4'hF);
    expRead("R10 intline", 32'h3C, 32'h0000_00FF);
  endtask

  task automatic tReReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R11 enables after reset", {30'd0, memEnable, ioEnable}, 32'd0);
    expRead("R11 bar0 cleared", 32'h10, 32'h0);
    expRead("R11 command cleared", 32'h04, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tIdentity();
    tCommand();
    tNoClaim();
    tBars();
    tReserved();
    tReReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chkCount++; errCount++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule